// File: doc/BRIEF.md
# Dual-Core Boot-Hold Wakeup Sequencer

This block keeps the power state of a system built around two processors: a primary core that always starts first and a secondary core that is parked in a boot-hold stop state until software on the primary core lets it go. It tracks each core as running, sleeping or stopped, derives the overall system mode (run, stop or standby), and decides which core a wakeup event actually reaches.

The secondary core may only come out of stop while the software-owned release bit is set. A wakeup aimed at the secondary core that arrives while the bit is clear is not lost. It is latched as pending, a redirect flag is raised, and the primary core is woken instead. Once the primary core sets the release bit, the pending wakeup starts the secondary core, and the primary core is then free to stop again. Entering standby clears the release bit and puts the secondary core back into boot hold.

Top module: `dual_boot_wake_ctrl`

## Requirements
- R1: After reset the primary core state reads 0 (run) and the secondary state reads 3 (boot hold). The release bit, the redirect flag and the system mode read 0, the primary clock enable is 1 and the secondary clock enable is 0. Core state codes are 0 run, 1 sleep, 2 stop and 3 boot hold. System mode codes are 0 run, 1 stop and 2 standby.
- R2: While the release bit reads 0, a secondary core in stop (2) or boot hold (3) remains in one of those states at the next clock edge.
- R3: A secondary wakeup that arrives while the release bit is 0 and the secondary core is not running sets the redirect flag and moves a non-running primary core to run, both at the next edge. The wakeup is latched as pending. A secondary wakeup while the secondary core runs raises no redirect.
- R4: When the release bit reads 1 and a secondary wakeup is pending, the secondary core enters run at the next edge and the pending wakeup is cleared. The primary core may stop afterwards without affecting the secondary core.
- R5: With the release bit at 1, a secondary wakeup source moves a stopped or sleeping secondary core to run at the next edge without touching the primary core or the redirect flag.
- R6: A primary wakeup source moves a sleeping or stopped primary core to run at the next edge and leaves a held secondary core in boot hold.
- R7: The release-set strobe sets the release bit at the next edge and the release-clear strobe clears it. When both arrive in the same cycle, clear wins.
- R8: The redirect-clear strobe clears the redirect flag at the next edge. A redirect event in the same cycle wins, and the flag stays 1.
- R9: The system mode reads run while either core is running or sleeping, and reads stop when both cores are stopped or held.
- R10: A standby request is taken only when both cores are stopped or held and no wakeup is arriving or due in that cycle. Taking it sets the system mode to standby, clears the release bit (even against a set strobe in the same cycle) and puts the secondary core in boot hold. A later primary wakeup, or a redirected secondary wakeup, returns the system to run with the primary core running.
- R11: A stop request moves a running or sleeping core to stop. A sleep request moves a running core to sleep, and stop wins over sleep. A wake for a core that is not running moves it to run and wins over a stop request in the same cycle.
- R12: Each core's clock enable is 1 exactly when that core's state reads run. It changes at the same edge as the state, one cycle after the wake or stop decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_stop_req | input | 1 | Primary core requests stop |
| pri_sleep_req | input | 1 | Primary core requests sleep |
| pri_wake_src | input | 1 | Wakeup source routed to the primary core |
| sec_stop_req | input | 1 | Secondary core requests stop |
| sec_sleep_req | input | 1 | Secondary core requests sleep |
| sec_wake_src | input | 1 | Wakeup source routed to the secondary core |
| boot_rel_set | input | 1 | Strobe that sets the release bit |
| boot_rel_clr | input | 1 | Strobe that clears the release bit |
| redir_clr | input | 1 | Write-one-to-clear strobe for the redirect flag |
| standby_req | input | 1 | Request to enter standby |
| boot_rel | output | 1 | Release bit |
| redir_flag | output | 1 | Sticky redirect flag |
| pri_state | output | 2 | Primary core state code |
| sec_state | output | 2 | Secondary core state code |
| pri_clk_en | output | 1 | Primary core clock enable |
| sec_clk_en | output | 1 | Secondary core clock enable |
| sys_mode | output | 2 | System mode code |

## Verification
Two pairs of functions can meet in one cycle. The redirect event can coincide with the redirect-clear strobe, and standby entry can coincide with a release-set strobe or with an incoming wakeup. The bench drives each pair in the same cycle on purpose: a secondary wakeup together with the clear strobe, standby together with the set strobe, and standby together with a primary wakeup. It then checks that the redirect flag stays set, that the release bit ends up clear, and that the system stays in run and never reaches standby.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

    localparam int NCORE = 2;
    localparam int PRI   = 0;
    localparam int SEC   = 1;

    typedef enum logic [1:0] {
        CS_RUN   = 2'd0,
        CS_SLEEP = 2'd1,
        CS_STOP  = 2'd2,
        CS_HOLD  = 2'd3
    } core_st_e;

    typedef enum logic [1:0] {
        SM_RUN     = 2'd0,
        SM_STOP    = 2'd1,
        SM_STANDBY = 2'd2
    } sys_mode_e;

    function automatic logic is_parked(core_st_e s);
        return (s == CS_STOP) || (s == CS_HOLD);
    endfunction

    function automatic logic is_active(core_st_e s);
        return (s == CS_RUN) || (s == CS_SLEEP);
    endfunction

endpackage

// File: rtl/dbw_core_seq.sv
module dbw_core_seq
    import dbw_pkg::*;
#(
    parameter bit HOLD_PARK = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stop_req_i,
    input  logic     sleep_req_i,
    input  logic     wake_go_i,
    input  logic     park_i,
    output core_st_e state_o,
    output core_st_e state_nxt_o,
    output logic     clk_en_o
);

    localparam core_st_e PARK_ST = HOLD_PARK ? CS_HOLD : CS_STOP;
    localparam core_st_e RST_ST  = HOLD_PARK ? CS_HOLD : CS_RUN;

    typedef struct packed {
        core_st_e st;
        logic     cen;
    } core_reg_t;

    core_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (park_i) begin
            r_d.st = PARK_ST;
        end else if (wake_go_i && (r_q.st != CS_RUN)) begin
            r_d.st = CS_RUN;
        end else begin
            case (r_q.st)
                CS_RUN: begin
                    if (stop_req_i)       r_d.st = CS_STOP;
                    else if (sleep_req_i) r_d.st = CS_SLEEP;
                end
                CS_SLEEP: begin
                    if (stop_req_i)       r_d.st = CS_STOP;
                end
                default: ;
            endcase
        end
        r_d.cen = (r_d.st == CS_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RST_ST, cen: ~HOLD_PARK};
        else        r_q <= r_d;
    end

    assign state_o     = r_q.st;
    assign state_nxt_o = r_d.st;
    assign clk_en_o    = r_q.cen;

    AST_STOP_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!park_i && (r_q.st == CS_RUN) && stop_req_i) |=> (r_q.st == CS_STOP)); // R11

endmodule

// File: rtl/dbw_boot_gate.sv
module dbw_boot_gate
    import dbw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rel_set_i,
    input  logic     rel_clr_i,
    input  logic     standby_go_i,
    input  logic     sec_wake_i,
    input  logic     redir_clr_i,
    input  core_st_e sec_state_i,
    output logic     release_o,
    output logic     redirect_o,
    output logic     sec_go_o,
    output logic     redir_evt_o
);

    typedef struct packed {
        logic rel;
        logic pend;
        logic redir;
    } gate_reg_t;

    gate_reg_t r_d, r_q;
    logic      sec_idle;
    logic      redir_evt;
    logic      sec_go;

    always_comb begin
        sec_idle  = (sec_state_i != CS_RUN);
        redir_evt = sec_wake_i && !r_q.rel && sec_idle;
        sec_go    = r_q.rel && sec_idle && (sec_wake_i || r_q.pend);

        r_d = r_q;
        if (standby_go_i)   r_d.rel = 1'b0;
        else if (rel_clr_i) r_d.rel = 1'b0;
        else if (rel_set_i) r_d.rel = 1'b1;

        if (sec_go) r_d.pend = 1'b0;
        else        r_d.pend = r_q.pend || (sec_wake_i && sec_idle);

        r_d.redir = redir_evt || (r_q.redir && !redir_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign release_o   = r_q.rel;
    assign redirect_o  = r_q.redir;
    assign sec_go_o    = sec_go;
    assign redir_evt_o = redir_evt;

    AST_REL_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rel_clr_i |=> !r_q.rel); // R7

    AST_REDIR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_clr_i && !sec_wake_i) |=> !r_q.redir); // R8

    AST_PEND_GONE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_state_i == CS_RUN) |-> !r_q.pend); // R4

endmodule

// File: rtl/dual_boot_wake_ctrl.sv
module dual_boot_wake_ctrl
    import dbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_stop_req,
    input  logic       pri_sleep_req,
    input  logic       pri_wake_src,
    input  logic       sec_stop_req,
    input  logic       sec_sleep_req,
    input  logic       sec_wake_src,
    input  logic       boot_rel_set,
    input  logic       boot_rel_clr,
    input  logic       redir_clr,
    input  logic       standby_req,
    output logic       boot_rel,
    output logic       redir_flag,
    output logic [1:0] pri_state,
    output logic [1:0] sec_state,
    output logic       pri_clk_en,
    output logic       sec_clk_en,
    output logic [1:0] sys_mode
);

    logic [NCORE-1:0] stop_v, sleep_v, wake_v, cen_v;
    core_st_e         st_v  [NCORE];
    core_st_e         nxt_v [NCORE];
    logic             sec_go, redir_evt, standby_go;

    typedef struct packed {
        sys_mode_e sm;
    } top_reg_t;

    top_reg_t r_d, r_q;

    assign stop_v  = {sec_stop_req, pri_stop_req};
    assign sleep_v = {sec_sleep_req, pri_sleep_req};
    assign wake_v  = {sec_go, pri_wake_src || redir_evt};

    always_comb begin
        standby_go = standby_req && is_parked(st_v[PRI]) && is_parked(st_v[SEC])
                     && !pri_wake_src && !sec_wake_src && !sec_go;
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        dbw_core_seq #(.HOLD_PARK(g == SEC)) u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .stop_req_i  (stop_v[g]),
            .sleep_req_i (sleep_v[g]),
            .wake_go_i   (wake_v[g]),
            .park_i      (standby_go),
            .state_o     (st_v[g]),
            .state_nxt_o (nxt_v[g]),
            .clk_en_o    (cen_v[g])
        );
    end

    dbw_boot_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .rel_set_i    (boot_rel_set),
        .rel_clr_i    (boot_rel_clr),
        .standby_go_i (standby_go),
        .sec_wake_i   (sec_wake_src),
        .redir_clr_i  (redir_clr),
        .sec_state_i  (st_v[SEC]),
        .release_o    (boot_rel),
        .redirect_o   (redir_flag),
        .sec_go_o     (sec_go),
        .redir_evt_o  (redir_evt)
    );

    always_comb begin
        r_d = r_q;
        if (standby_go)
            r_d.sm = SM_STANDBY;
        else if (is_active(nxt_v[PRI]) || is_active(nxt_v[SEC]))
            r_d.sm = SM_RUN;
        else if (r_q.sm == SM_STANDBY)
            r_d.sm = SM_STANDBY;
        else
            r_d.sm = SM_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sm: SM_RUN};
        else        r_q <= r_d;
    end

    assign pri_state  = st_v[PRI];
    assign sec_state  = st_v[SEC];
    assign pri_clk_en = cen_v[PRI];
    assign sec_clk_en = cen_v[SEC];
    assign sys_mode   = r_q.sm;

    AST_SEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_parked(st_v[SEC]) && !boot_rel) |=> is_parked(st_v[SEC])); // R2

    AST_REDIR_WAKES_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_wake_src && !boot_rel && (st_v[SEC] != CS_RUN) && (st_v[PRI] != CS_RUN))
        |=> ((st_v[PRI] == CS_RUN) && redir_flag)); // R3

    AST_PRI_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_wake_src && (st_v[PRI] != CS_RUN)) |=> (st_v[PRI] == CS_RUN)); // R6

    AST_SYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_active(st_v[PRI]) || is_active(st_v[SEC])) |-> (r_q.sm == SM_RUN)); // R9

    AST_STBY_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.sm != SM_STANDBY) && !(is_parked(st_v[PRI]) && is_parked(st_v[SEC])))
        |=> (r_q.sm != SM_STANDBY)); // R10

    AST_STBY_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sm != SM_STANDBY)
        |=> ((r_q.sm != SM_STANDBY) || (!boot_rel && (st_v[SEC] == CS_HOLD)))); // R10

endmodule

// File: tb/dual_boot_wake_ctrl_tb_top.sv
module dual_boot_wake_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pri_stop_req = 0, pri_sleep_req = 0, pri_wake_src = 0;
    logic       sec_stop_req = 0, sec_sleep_req = 0, sec_wake_src = 0;
    logic       boot_rel_set = 0, boot_rel_clr = 0, redir_clr = 0, standby_req = 0;
    logic       boot_rel, redir_flag, pri_clk_en, sec_clk_en;
    logic [1:0] pri_state, sec_state, sys_mode;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct {
        string      tag;
        logic [9:0] exp;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    dual_boot_wake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .pri_stop_req(pri_stop_req), .pri_sleep_req(pri_sleep_req), .pri_wake_src(pri_wake_src),
        .sec_stop_req(sec_stop_req), .sec_sleep_req(sec_sleep_req), .sec_wake_src(sec_wake_src),
        .boot_rel_set(boot_rel_set), .boot_rel_clr(boot_rel_clr), .redir_clr(redir_clr),
        .standby_req(standby_req), .boot_rel(boot_rel), .redir_flag(redir_flag),
        .pri_state(pri_state), .sec_state(sec_state), .pri_clk_en(pri_clk_en),
        .sec_clk_en(sec_clk_en), .sys_mode(sys_mode)
    );

    // Expected bundle: pri, sec, sys, release, redirect, clock enables (R12: enable == run)
    function automatic logic [9:0] mk(logic [1:0] ps, logic [1:0] ss, logic [1:0] sm,
                                      logic rel, logic rd);
        return {ps, ss, sm, rel, rd, (ps == 2'd0), (ss == 2'd0)};
    endfunction

    task automatic tick(input string tag, input logic [9:0] e);
        item_t it;
        it.tag = tag;
        it.exp = e;
        sb_q.push_back(it);
        @(negedge clk);
        {pri_stop_req, pri_sleep_req, pri_wake_src, sec_stop_req, sec_sleep_req,
         sec_wake_src, boot_rel_set, boot_rel_clr, redir_clr, standby_req} = '0;
    endtask

    // Monitor: compare one queued item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [9:0] act;
                it  = sb_q.pop_front();
                act = {pri_state, sec_state, sys_mode, boot_rel, redir_flag, pri_clk_en, sec_clk_en};
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick("R1 reset state", mk(0, 3, 0, 0, 0));
        pri_sleep_req = 1;              tick("R11 pri sleep", mk(1, 3, 0, 0, 0));
        pri_stop_req = 1;               tick("R9 both parked -> stop", mk(2, 3, 1, 0, 0));
        pri_wake_src = 1;               tick("R6 pri wake only", mk(0, 3, 0, 0, 0));
        pri_stop_req = 1; pri_sleep_req = 1; tick("R11 stop beats sleep", mk(2, 3, 1, 0, 0));
        sec_wake_src = 1;               tick("R3 redirect to pri", mk(0, 3, 0, 0, 1));
        tick("R2 sec still held", mk(0, 3, 0, 0, 1));
        redir_clr = 1; sec_wake_src = 1; tick("R8 event beats clear", mk(0, 3, 0, 0, 1));
        redir_clr = 1;                  tick("R8 w1c clear", mk(0, 3, 0, 0, 0));
        boot_rel_set = 1;               tick("R7 release set", mk(0, 3, 0, 1, 0));
        tick("R4 pending wake starts sec", mk(0, 0, 0, 1, 0));
        pri_stop_req = 1;               tick("R4 pri stops alone", mk(2, 0, 0, 1, 0));
        sec_stop_req = 1;               tick("R9 both stop", mk(2, 2, 1, 1, 0));
        tick("R4 pending cleared", mk(2, 2, 1, 1, 0));
        boot_rel_set = 1; boot_rel_clr = 1; tick("R7 clear wins", mk(2, 2, 1, 0, 0));
        sec_wake_src = 1;               tick("R3 redirect from stop", mk(0, 2, 0, 0, 1));
        redir_clr = 1;                  tick("R8 clear", mk(0, 2, 0, 0, 0));
        pri_stop_req = 1;               tick("R9 stop", mk(2, 2, 1, 0, 0));
        standby_req = 1; pri_wake_src = 1; tick("R10 standby refused on wake", mk(0, 2, 0, 0, 0));
        pri_stop_req = 1;               tick("R9 stop again", mk(2, 2, 1, 0, 0));
        standby_req = 1; boot_rel_set = 1; tick("R10 standby entry clears release", mk(2, 3, 2, 0, 0));
        tick("R10 standby held", mk(2, 3, 2, 0, 0));
        pri_wake_src = 1;               tick("R10 exit by pri wake", mk(0, 3, 0, 0, 0));
        pri_stop_req = 1;               tick("R9 stop", mk(2, 3, 1, 0, 0));
        standby_req = 1;                tick("R10 standby entry", mk(2, 3, 2, 0, 0));
        sec_wake_src = 1;               tick("R10 exit by redirected wake", mk(0, 3, 0, 0, 1));
        redir_clr = 1;                  tick("R8 clear", mk(0, 3, 0, 0, 0));
        standby_req = 1;                tick("R10 standby refused while running", mk(0, 3, 0, 0, 0));
        boot_rel_set = 1;               tick("R7 set in run mode", mk(0, 3, 0, 1, 0));
        tick("R4 pending from standby exit", mk(0, 0, 0, 1, 0));
        sec_sleep_req = 1;              tick("R12 sec sleep gates clock", mk(0, 1, 0, 1, 0));
        sec_wake_src = 1;               tick("R5 sec wake from sleep", mk(0, 0, 0, 1, 0));
        sec_stop_req = 1;               tick("R11 sec stop", mk(0, 2, 0, 1, 0));
        sec_wake_src = 1;               tick("R5 direct sec wake", mk(0, 0, 0, 1, 0));
        sec_stop_req = 1;               tick("R11 sec stop", mk(0, 2, 0, 1, 0));
        sec_wake_src = 1; sec_stop_req = 1; tick("R11 wake beats stop", mk(0, 0, 0, 1, 0));
        boot_rel_clr = 1;               tick("R7 release clear", mk(0, 0, 0, 0, 0));
        sec_wake_src = 1;               tick("R3 no redirect while sec runs", mk(0, 0, 0, 0, 0));
        pri_stop_req = 1;               tick("R12 pri stop drops enable", mk(2, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule